// File: doc/BRIEF.md
# Serial Configuration Loader

This block is a configuration master for a downstream programmable device that accepts its image over a slave-serial link. A one-cycle `start` launches a fixed sequence. First the program-request pin `prog_n` goes low for a set number of system cycles and is then released. Next the block polls the device's init-ready pin until it rises, and gives up after a limit. It then shifts a requested number of bytes from an upstream byte stream out on `din` under a divided configuration clock `cclk`. After the last byte it keeps pulsing `cclk` until the device raises its done pin, with a second, independent limit on those pulses.

Each byte is taken through a valid/ready handshake. A byte may carry an error flag from upstream, and that flag aborts the load. Before use, the init-ready and done pins each pass through a two-flop synchronizer. Three status outputs report the run. `busy` covers the whole sequence, and exactly one of `ok` or `err` is raised at its end and held until the next start.

Top module: `cfgser_seq`

## Requirements
- R1: Out of reset and whenever not busy, `prog_n` is 1, `cclk` is 0, `din` is 0, `s_ready` is 0 and `busy` is 0; `ok` and `err` are both 0 after reset.
- R2: Each accepted start drives `prog_n` low for exactly PROG_LOW system cycles, once, and `cclk` stays 0 while `prog_n` is low.
- R3: If the synchronized init-ready input is not seen high within INIT_POLLS polls after release, the run ends with `err`=1 and no `cclk` rising edge and no byte accepted.
- R4: Bytes leave most significant bit first, one bit per `cclk` rising edge. `cclk` stays high for exactly CCLK_HALF cycles, and `din` does not change at a rising edge or while `cclk` is high.
- R5: Exactly `byte_count` bytes are shifted (8 rising edges per byte). A count of 0 skips the data phase and goes straight to the done-wait pulses.
- R6: A byte presented with `s_err`=1 is consumed and not shifted. The run then ends at once with `err`=1 and sends no further bytes or pulses.
- R7: After the data, `cclk` keeps pulsing until the synchronized done input is seen high at the start of a pulse slot. The run then ends with `ok`=1, and `ok` is never raised without done having been seen.
- R8: If done is not seen, the run ends with `err`=1 after exactly DONE_PULSES extra `cclk` pulses.
- R9: `busy` is 1 from the cycle after an accepted start until `ok` or `err` rises. A `start` while busy is ignored, and `ok`/`err` hold their value until the next start.
- R10: Done first seen at the check that follows the DONE_PULSES-th extra pulse counts as success (`ok`=1, not `err`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | one-cycle request to begin a load |
| byte_count | input | CNT_W | number of bytes to send, sampled at start |
| s_valid | input | 1 | upstream byte valid |
| s_data | input | 8 | upstream byte |
| s_err | input | 1 | upstream error flag accompanying the byte |
| s_ready | output | 1 | block accepts a byte this cycle |
| init_pin | input | 1 | device init-ready, active high, asynchronous |
| done_pin | input | 1 | device configuration done, asynchronous |
| prog_n | output | 1 | program request to device, active low |
| cclk | output | 1 | configuration clock |
| din | output | 1 | configuration data |
| busy | output | 1 | sequence in progress |
| ok | output | 1 | last run finished with done seen |
| err | output | 1 | last run ended by a timeout or upstream error |

## Verification
The closest collision in this block happens when done arrives at the very check where the post-data pulse counter has reached its limit. In that case the decision between success and timeout is made in one cycle. The bench provokes this by having the device model raise done after exactly DONE_PULSES extra rising edges, and again after one more. It expects `ok` with DONE_PULSES pulses in the first case and `err` with the same pulse count in the second. A second overlap, a fresh `start` arriving while a load is running, is injected mid-transfer and judged by there being a single program pulse and an unchanged byte and pulse count.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WAIT,
        ST_FETCH,
        ST_SHIFT,
        ST_POST,
        ST_OK,
        ST_ERR
    } seq_state_t;

    typedef enum logic {
        PH_LOW,
        PH_HIGH
    } clk_phase_t;

    // width able to hold values 0..limit
    function automatic int unsigned cnt_width(int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/cfgser_sync2.sv
module cfgser_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/cfgser_tick.sv
module cfgser_tick #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    import cfgser_pkg::*;

    localparam int unsigned W = cnt_width(HALF);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/cfgser_shreg.sv
module cfgser_shreg (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [cfgser_pkg::BYTE_W-1:0] data,
    input  logic                         shift,
    output logic                         msb,
    output logic                         last
);
    import cfgser_pkg::*;

    localparam int unsigned IW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sreg;
    logic [IW-1:0]     idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= data;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[BYTE_W-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign msb  = sreg[BYTE_W-1];
    assign last = (idx == IW'(BYTE_W - 1));
endmodule

// File: rtl/cfgser_seq.sv
module cfgser_seq #(
    parameter int unsigned PROG_LOW    = 1200,
    parameter int unsigned CCLK_HALF   = 3,
    parameter int unsigned INIT_POLLS  = 100000,
    parameter int unsigned DONE_PULSES = 100000,
    parameter int unsigned CNT_W       = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_err,
    output logic             s_ready,
    input  logic             init_pin,
    input  logic             done_pin,
    output logic             prog_n,
    output logic             cclk,
    output logic             din,
    output logic             busy,
    output logic             ok,
    output logic             err
);
    import cfgser_pkg::*;

    localparam int unsigned HOLD_W  = cnt_width(PROG_LOW);
    localparam int unsigned POLL_W  = cnt_width(INIT_POLLS);
    localparam int unsigned PULSE_W = cnt_width(DONE_PULSES);
    localparam logic [HOLD_W-1:0]  HOLD_LAST  = HOLD_W'(PROG_LOW - 1);
    localparam logic [POLL_W-1:0]  POLL_LAST  = POLL_W'(INIT_POLLS - 1);
    localparam logic [PULSE_W-1:0] PULSE_LIM  = PULSE_W'(DONE_PULSES);

    seq_state_t       state;
    clk_phase_t       ph;
    logic             cclk_q;
    logic             prog_q;
    logic [HOLD_W-1:0]  hold_cnt;
    logic [POLL_W-1:0]  poll_cnt;
    logic [PULSE_W-1:0] pulse_cnt;
    logic [CNT_W-1:0]   sent;
    logic [CNT_W-1:0]   nbytes;

    logic init_s, done_s;
    logic tick, sh_msb, sh_last, sh_load, sh_shift;

    cfgser_sync2 #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({init_pin, done_pin}),
        .q   ({init_s, done_s})
    );

    cfgser_tick #(.HALF(CCLK_HALF)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  ((state == ST_SHIFT) || (state == ST_POST)),
        .tick (tick)
    );

    assign sh_load  = (state == ST_FETCH) && s_valid && !s_err;
    assign sh_shift = (state == ST_SHIFT) && tick && (ph == PH_HIGH);

    cfgser_shreg u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .data  (s_data),
        .shift (sh_shift),
        .msb   (sh_msb),
        .last  (sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ph        <= PH_LOW;
            cclk_q    <= 1'b0;
            prog_q    <= 1'b1;
            hold_cnt  <= '0;
            poll_cnt  <= '0;
            pulse_cnt <= '0;
            sent      <= '0;
            nbytes    <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_OK, ST_ERR: begin
                    if (start) begin
                        state     <= ST_PROG;
                        prog_q    <= 1'b0;
                        hold_cnt  <= '0;
                        poll_cnt  <= '0;
                        pulse_cnt <= '0;
                        sent      <= '0;
                        nbytes    <= byte_count;
                        cclk_q    <= 1'b0;
                        ph        <= PH_LOW;
                    end
                end
                ST_PROG: begin
                    if (hold_cnt == HOLD_LAST) begin
                        prog_q <= 1'b1;
                        state  <= ST_WAIT;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (init_s) begin
                        state <= (nbytes == '0) ? ST_POST : ST_FETCH;
                    end else if (poll_cnt == POLL_LAST) begin
                        state <= ST_ERR;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (s_valid) begin
                        state <= s_err ? ST_ERR : ST_SHIFT;
                        ph    <= PH_LOW;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (ph == PH_LOW) begin
                            cclk_q <= 1'b1;
                            ph     <= PH_HIGH;
                        end else begin
                            cclk_q <= 1'b0;
                            ph     <= PH_LOW;
                            if (sh_last) begin
                                sent  <= sent + 1'b1;
                                state <= ((sent + CNT_W'(1)) == nbytes) ? ST_POST : ST_FETCH;
                            end
                        end
                    end
                end
                ST_POST: begin
                    if (tick) begin
                        if (ph == PH_LOW) begin
                            if (done_s) begin
                                state <= ST_OK;
                            end else if (pulse_cnt == PULSE_LIM) begin
                                state <= ST_ERR;
                            end else begin
                                cclk_q    <= 1'b1;
                                ph        <= PH_HIGH;
                                pulse_cnt <= pulse_cnt + 1'b1;
                            end
                        end else begin
                            cclk_q <= 1'b0;
                            ph     <= PH_LOW;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign prog_n  = prog_q;
    assign cclk    = cclk_q;
    assign din     = (state == ST_SHIFT) ? sh_msb : 1'b0;
    assign s_ready = (state == ST_FETCH);
    assign ok      = (state == ST_OK);
    assign err     = (state == ST_ERR);
    assign busy    = (state != ST_IDLE) && (state != ST_OK) && (state != ST_ERR);

    assert_pins_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (prog_n && !cclk && !din && !s_ready));

    assert_no_clk_in_prog_R2: assert property (@(posedge clk) disable iff (rst)
        !prog_n |-> !cclk);

    assert_din_steady_R4: assert property (@(posedge clk) disable iff (rst)
        cclk |-> $stable(din));

    assert_ok_needs_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ok) |-> $past(done_s));

    assert_busy_ends_in_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (ok ^ err));
endmodule

// File: tb/test_cfgser_seq.sv
module test_cfgser_seq;
    localparam int PERIOD      = 10;
    localparam int PROG_LOW    = 5;
    localparam int CCLK_HALF   = 2;
    localparam int INIT_POLLS  = 20;
    localparam int DONE_PULSES = 6;
    localparam int CNT_W       = 16;
    localparam int NCASE       = 8;

    // columns: byte count, init delay (-1 never), done after N extra pulses (-1 never),
    //          upstream error at byte index (-1 none), expected ok, extra start after N cycles (-1 none)
    localparam int VEC [NCASE][6] = '{
        '{3,  3,  2, -1, 1, 15},
        '{1,  0,  0, -1, 1, -1},
        '{0,  2,  1, -1, 1, -1},
        '{2, -1, -1, -1, 0, -1},
        '{4,  5, -1, -1, 0, -1},
        '{2,  1,  6, -1, 1, -1},
        '{3,  1,  7, -1, 0, -1},
        '{5,  2,  1,  2, 0, -1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic s_valid, s_err, s_ready;
    logic [7:0] s_data;
    logic init_pin = 1'b0;
    logic done_pin = 1'b0;
    logic prog_n, cclk, din, busy, ok, err;

    always #(PERIOD/2) clk = ~clk;

    cfgser_seq #(
        .PROG_LOW(PROG_LOW), .CCLK_HALF(CCLK_HALF), .INIT_POLLS(INIT_POLLS),
        .DONE_PULSES(DONE_PULSES), .CNT_W(CNT_W)
    ) i_cfgser_seq (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .s_valid(s_valid), .s_data(s_data), .s_err(s_err), .s_ready(s_ready),
        .init_pin(init_pin), .done_pin(done_pin),
        .prog_n(prog_n), .cclk(cclk), .din(din),
        .busy(busy), .ok(ok), .err(err)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cur_n = 0, cur_init = -1, cur_done = -1, cur_errat = -1;
    logic mon_clr = 1'b1;

    function automatic logic [7:0] byte_at(int i);
        return 8'(i * 53 + 8'hA5);
    endfunction

    // upstream byte source
    int idx = 0;
    always @(posedge clk) begin
        if (mon_clr) idx <= 0;
        else if (s_valid && s_ready) idx <= idx + 1;
    end
    assign s_valid = !mon_clr;
    assign s_data  = byte_at(idx);
    assign s_err   = (idx == cur_errat);

    // device model and pin monitor
    int since_rel, rises, hi_run, hi_bad, low_run, prog_pulses, prog_low_last, bitc, nbyt;
    logic prog_prev, cclk_prev;
    logic [7:0] acc;
    logic [7:0] cap [0:15];

    always @(negedge clk) begin
        if (mon_clr) begin
            since_rel = -1; rises = 0; hi_run = 0; hi_bad = 0; low_run = 0;
            prog_pulses = 0; prog_low_last = 0; bitc = 0; nbyt = 0;
            prog_prev = 1'b1; cclk_prev = 1'b0; acc = '0;
            init_pin = 1'b0; done_pin = 1'b0;
        end else begin
            if (!prog_n) begin
                low_run++;
                since_rel = -1;
            end else if (!prog_prev) begin
                prog_pulses++;
                prog_low_last = low_run;
                low_run = 0;
                since_rel = 0;
            end else if (since_rel >= 0) begin
                since_rel++;
            end
            prog_prev = prog_n;
            init_pin = (cur_init >= 0) && (since_rel >= cur_init);
            if (cclk && !cclk_prev) begin
                rises++;
                hi_run = 1;
                acc = {acc[6:0], din};
                bitc++;
                if (bitc == 8) begin
                    if (nbyt < 16) cap[nbyt] = acc;
                    nbyt++;
                    bitc = 0;
                end
            end else if (cclk) begin
                hi_run++;
            end
            if (!cclk && cclk_prev && hi_run != CCLK_HALF) hi_bad++;
            cclk_prev = cclk;
            done_pin = (cur_done >= 0) && (rises >= 8 * cur_n + cur_done);
        end
    end

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9: watchdog expired, got %0d expected 0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic run_case(int n, int idl, int da, int ea, int exp_ok, int restart);
        int w;
        bit init_ok;
        int bytes_exp, post_exp;
        @(posedge clk); #1;
        mon_clr = 1'b1;
        cur_n = n; cur_init = idl; cur_done = da; cur_errat = ea;
        byte_count = CNT_W'(n);
        @(posedge clk); #1;
        mon_clr = 1'b0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        chk("R9 busy after start", int'(busy), 1);
        w = 0;
        while (busy && w < 4000) begin
            if (w == restart) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            w++;
        end
        start = 1'b0;
        if (w >= 4000) chk("R9 run ended", 0, 1);

        init_ok   = (idl >= 0) && (idl < INIT_POLLS / 2);
        bytes_exp = !init_ok ? 0 : (ea >= 0 ? ea : n);
        post_exp  = (!init_ok || ea >= 0) ? 0 :
                    ((da < 0 || da > DONE_PULSES) ? DONE_PULSES : da);

        chk("R7/R8/R10 ok", int'(ok), exp_ok);
        chk("R3/R6/R8 err", int'(err), 1 - exp_ok);
        chk("R2 prog low width", prog_low_last, PROG_LOW);
        chk("R2/R9 single prog pulse", prog_pulses, 1);
        chk("R5/R3/R6 bytes shifted", nbyt, bytes_exp);
        chk("R7/R8 extra pulses", rises - 8 * nbyt, post_exp);
        chk("R4 cclk high width", hi_bad, 0);
        for (int i = 0; i < bytes_exp && i < 16 && i < nbyt; i++)
            chk("R4 byte MSB first", int'(cap[i]), int'(byte_at(i)));
        repeat (5) @(negedge clk);
        chk("R9 outcome held", int'(ok) * 2 + int'(err), exp_ok ? 2 : 1);
        chk("R1 pins quiet after run", int'({prog_n, cclk, din, s_ready}), 8);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset busy", int'(busy), 0);
        chk("R1 reset ok/err", int'({ok, err}), 0);
        chk("R1 reset pins", int'({prog_n, cclk, din, s_ready}), 8);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'({prog_n, cclk, din, busy, ok, err}), 32);

        for (int c = 0; c < NCASE; c++)
            run_case(VEC[c][0], VEC[c][1], VEC[c][2], VEC[c][3], VEC[c][4], VEC[c][5]);

        // directed: zero bytes with done already pending gives ok with no pulses (R5)
        run_case(0, 1, 0, -1, 1, -1);
        // directed: error on very first byte (R6)
        run_case(3, 0, -1, 0, 0, -1);
        // directed: init arrives well past the poll limit (R3)
        run_case(1, 40, 0, -1, 0, -1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule